// File: doc/BRIEF.md
# Banked Serial-to-Parallel Converter

This block gathers a 1-bit serial stream into 16-bit words. Instead of one 16-stage shift chain that moves on every accepted bit, it spreads the incoming bits over four 4-bit lane registers in strict rotation. Each lane therefore advances only on every fourth accepted bit. When the sixteenth bit of a word arrives, a 16-bit word register loads the lane contents directly, with no output selector. The lane bits are interleaved on that load, so the word is identical to the one a plain MSB-first shift-in converter would produce.

A producer presents one bit per cycle on `ser_in` together with `ser_vld`. It may leave idle cycles at any point. Idle cycles freeze the converter, and the partial word is kept. Each finished word appears on `word_out`, and `word_vld` pulses high for one cycle. The word stays on `word_out` until the next word completes. The reduced-rate lanes are clock enables on the single clock `clk`. Word framing and start detection belong to the surrounding logic.

Top module: `deser_banked`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the converter clears its bit count, its lanes, `word_out` and `word_vld`. After reset, `word_out` reads 0 and `word_vld` reads 0 until a word completes.
- R2: Each word is taken MSB-first. The first accepted bit of a word appears at `word_out[15]`, and the sixteenth appears at `word_out[0]`.
- R3: `word_vld` is high for exactly one cycle per 16 accepted bits. It rises in the cycle after the edge that accepts the sixteenth bit, and it is never high in two consecutive cycles.
- R4: A cycle with `ser_vld` low has no effect, whatever value `ser_in` carries. The bit count and the partial word are held across idle stretches of any length.
- R5: Accepted bit k of a word (k = 0..15) shifts into lane k mod 4 only. At most one lane advances per cycle, and lane j advances on every fourth accepted bit.
- R6: `word_out` changes only together with a `word_vld` pulse and otherwise holds the last completed word.
- R7: A reset in the middle of a word discards the bits received so far. The next 16 accepted bits form a fresh word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| ser_vld | input | 1 | High when `ser_in` carries a bit to accept |
| word_out | output | 16 | Last completed word, MSB-first order |
| word_vld | output | 1 | One-cycle strobe marking a newly loaded `word_out` |

## Verification
The hardest situation to reach is the completion edge. There the last lane has not yet shifted, so the word register must take the incoming bit straight from `ser_in` while the other three lanes are read as stored. That edge must also fall after an arbitrary pattern of idle cycles. The stimulus places idle gaps at every bit position across the table words, including directly before the sixteenth bit. It also sends words back to back with no gap, so a completion edge coincides with the first bit of the next word. Idle cycles carry random `ser_in` values, so any bit leaked from an idle cycle shows up as a wrong word bit.

// File: rtl/deser_pkg.sv
// Shared constants for the banked deserializer.
// Assumes the lane count is a power of two and each lane holds at least two bits.
package deser_pkg;
    parameter int DEF_LANES  = 4;
    parameter int DEF_LANE_W = 4;
endpackage

// File: rtl/deser_bit_seq.sv
// Bit sequencer: counts accepted bits within a word and selects the lane
// that takes the current bit. Assumes LANES is a power of two.
module deser_bit_seq #(
    parameter int LANES  = deser_pkg::DEF_LANES,
    parameter int LANE_W = deser_pkg::DEF_LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_vld,
    output logic [LANES-1:0] lane_en,
    output logic             word_done
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] sel;

    // Advance the bit count on each accepted bit, wrapping after the last bit of a word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ser_vld)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // The low bits of the count pick the lane (bit k goes to lane k mod LANES).
    assign sel       = SEL_W'(cnt);
    assign word_done = ser_vld && (cnt == LAST);

    // One enable per lane; only the selected lane moves, and only on an accepted bit.
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_en
            assign lane_en[j] = ser_vld && (sel == SEL_W'(j));
        end
    endgenerate

    // Assertion arming flag: goes high one cycle after reset is released.
    logic arm;
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= 1'b0;
        else        arm <= 1'b1;
    end

    a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_en));
    a_r4_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !ser_vld) |=> $stable(cnt));
    a_r3_wrap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (cnt == '0));
endmodule

// File: rtl/deser_lane.sv
// One lane register: a small shift register that takes a new bit at its
// least significant end whenever its enable is high and holds otherwise.
module deser_lane #(
    parameter int LANE_W = deser_pkg::DEF_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              din,
    output logic [LANE_W-1:0] q
);
    // Shift toward the MSB on enable so the oldest bit ends at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= {q[LANE_W-2:0], din};
    end

    // Assertion arming flag.
    logic arm;
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= 1'b0;
        else        arm <= 1'b1;
    end

    a_r4_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !en) |=> $stable(q));
endmodule

// File: rtl/deser_word_pack.sv
// Word packer: on word completion, interleaves the lane bits into one word
// in MSB-first order and loads the word register. The last lane has not
// shifted yet at that edge, so its view includes the incoming serial bit.
module deser_word_pack #(
    parameter int LANES  = deser_pkg::DEF_LANES,
    parameter int LANE_W = deser_pkg::DEF_LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0][LANE_W-1:0] lanes,
    input  logic                         ser_in,
    input  logic                         word_done,
    output logic [LANES*LANE_W-1:0]      word_out,
    output logic                         word_vld
);
    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0][LANE_W-1:0] view;
    logic [WORD_W-1:0]            packed_word;

    // Build each lane's final content; only the last lane still needs the incoming bit.
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_view
            if (j == LANES - 1) begin : g_last
                assign view[j] = {lanes[j][LANE_W-2:0], ser_in};
            end else begin : g_stored
                assign view[j] = lanes[j];
            end
        end
        // Bit k = i*LANES + j sits in lane j at slot LANE_W-1-i; place it at WORD_W-1-k.
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            for (genvar i = 0; i < LANE_W; i++) begin : g_slot
                assign packed_word[WORD_W-1-(i*LANES+j)] = view[j][LANE_W-1-i];
            end
        end
    endgenerate

    // Load the word once per completed word and strobe its validity for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= word_done;
            if (word_done)
                word_out <= packed_word;
        end
    end

    // Assertion arming flag.
    logic arm;
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= 1'b0;
        else        arm <= 1'b1;
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    a_r6_change_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && (word_out != $past(word_out))) |-> word_vld);
    a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> (word_out == '0 && !word_vld));
endmodule

// File: rtl/deser_banked.sv
// Banked serial-to-parallel converter: serial bits rotate over LANES lane
// registers, each advancing once per LANES accepted bits; a word register
// loads the interleaved lane bits once per LANES*LANE_W bits, MSB-first.
// Assumes LANES is a power of two and LANE_W >= 2.
module deser_banked #(
    parameter int LANES  = deser_pkg::DEF_LANES,
    parameter int LANE_W = deser_pkg::DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_in,
    input  logic                    ser_vld,
    output logic [LANES*LANE_W-1:0] word_out,
    output logic                    word_vld
);
    logic [LANES-1:0]             lane_en;
    logic                         word_done;
    logic [LANES-1:0][LANE_W-1:0] lanes;

    deser_bit_seq #(.LANES(LANES), .LANE_W(LANE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_vld   (ser_vld),
        .lane_en   (lane_en),
        .word_done (word_done)
    );

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            deser_lane #(.LANE_W(LANE_W)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (lane_en[j]),
                .din   (ser_in),
                .q     (lanes[j])
            );
        end
    endgenerate

    deser_word_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .lanes     (lanes),
        .ser_in    (ser_in),
        .word_done (word_done),
        .word_out  (word_out),
        .word_vld  (word_vld)
    );

    a_r5_done_on_last_lane: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> lane_en[LANES-1]);
endmodule

// File: tb/deser_banked_test.sv
`timescale 1ns/1ps
module deser_banked_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_vld = 1'b0;
    logic [15:0] word_out;
    logic        word_vld;

    int n_chk = 0;
    int n_bad = 0;
    int n_sent = 0;
    int n_got = 0;
    bit done = 1'b0;
    logic [15:0] expq[$];
    logic [15:0] last_out = '0;
    logic        prev_vld = 1'b0;

    // Table of {word, gap mask}: gap bit i inserts an idle cycle before word bit i.
    localparam logic [31:0] VEC [10] = '{
        {16'hA5C3, 16'h0000}, {16'h8000, 16'h0001}, {16'h0001, 16'h8000},
        {16'hFFFF, 16'hAAAA}, {16'h0000, 16'h5555}, {16'h1234, 16'hF00F},
        {16'hDEAD, 16'h0F0F}, {16'hBEEF, 16'h8421}, {16'h7FFE, 16'hFFFF},
        {16'h6A96, 16'h1248}
    };

    deser_banked uut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_vld(ser_vld),
        .word_out(word_out), .word_vld(word_vld)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        ser_vld = 1'b0;
        ser_in  = 1'($urandom);
    endtask

    task automatic send_word(input logic [15:0] w, input logic [15:0] gaps);
        expq.push_back(w);
        n_sent++;
        for (int i = 0; i < 16; i++) begin
            if (gaps[i]) idle_cycle();
            @(negedge clk);
            ser_vld = 1'b1;
            ser_in  = w[15-i];
        end
    endtask

    // Monitor: sample outputs at the falling edge, compare each strobed word (R2, R3, R6).
    always @(negedge clk) begin
        if (!rst_n) begin
            last_out = word_out;
            prev_vld = 1'b0;
        end else begin
            if (word_vld) begin
                n_got++;
                if (expq.size() == 0) begin
                    check(1'b0, "R3 strobe without word", 32'(word_out), 32'hXXXX);
                end else begin
                    check(word_out == expq[0], "R2 word value", 32'(word_out), 32'(expq[0]));
                    void'(expq.pop_front());
                end
                check(!prev_vld, "R3 single-cycle strobe", 32'(prev_vld), 32'd0);
            end else begin
                check(word_out == last_out, "R6 hold between words", 32'(word_out), 32'(last_out));
            end
            last_out = word_out;
            prev_vld = word_vld;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_out == 16'h0, "R1 word after reset", 32'(word_out), 32'h0);
        check(word_vld == 1'b0, "R1 strobe after reset", 32'(word_vld), 32'h0);

        // Table walk: R2, R4, R5 (every gap placement, idle ser_in randomized)
        for (int v = 0; v < 10; v++) begin
            send_word(VEC[v][31:16], VEC[v][15:0]);
        end
        idle_cycle();
        repeat (3) idle_cycle();

        // R3/R5: back-to-back words with no gap
        send_word(16'hC001, 16'h0000);
        send_word(16'h3FFC, 16'h0000);
        send_word(16'h9999, 16'h0000);
        repeat (3) idle_cycle();

        // R4: long idle stretch mid-word with toggling ser_in
        expq.push_back(16'hF0A5);
        n_sent++;
        for (int i = 0; i < 16; i++) begin
            if (i == 9) repeat (25) idle_cycle();
            @(negedge clk);
            ser_vld = 1'b1;
            ser_in  = 16'hF0A5 >> (15 - i);
        end
        repeat (3) idle_cycle();

        // R7: reset mid-word discards partial bits
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            ser_vld = 1'b1;
            ser_in  = 1'b1;
        end
        @(negedge clk);
        ser_vld = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_out == 16'h0, "R7 word cleared by mid-word reset", 32'(word_out), 32'h0);
        check(word_vld == 1'b0, "R7 no strobe after reset", 32'(word_vld), 32'h0);
        send_word(16'h0F3C, 16'h0000);
        repeat (3) idle_cycle();

        // Random words with random gaps (R2, R4)
        for (int r = 0; r < 40; r++) begin
            send_word(16'($urandom), 16'($urandom) & 16'($urandom));
        end
        repeat (4) idle_cycle();

        check(expq.size() == 0, "R3 every word strobed", 32'(expq.size()), 32'd0);
        check(n_got == n_sent - 0, "R3 strobe count", 32'(n_got), 32'(n_sent));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule